// File: doc/BRIEF.md
# Cache maintenance operation unit

This block carries out cache-maintenance requests against a small direct-mapped, write-back primary data cache that it holds itself. Each line of the cache keeps a tag, a valid bit, a dirty bit and its line data.

A request arrives already decoded: a base register value, a 16-bit signed offset, a cache selector, an operation code, the requester's privilege level, a coprocessor-enable bit and a cache-error control bit. The block forms the effective address and presents it to an external translation stub. It takes back a physical address and a fault flag in the same cycle.

Index operations pick a line from virtual address bits alone and never compare the tag. Hit operations act only when the addressed line is valid and its tag equals the physical address tag. Modified lines are written back one doubleword per beat on a memory write port. The write address is rebuilt from the stored tag and the line index. A single-cycle done pulse closes every accepted request, and the status flags and the load-tag result are valid in that cycle.

Top module: `cache_maint_unit`

## Requirements
- R1: `va_o` equals `base_i` plus `offset_i` sign-extended to the address width, combinationally.
- R2: Only cache selector value 1 (primary data) is acted on. Any other selector leaves the cache unchanged, issues no memory write and sets `undef_o` with done.
- R3: When `priv_i` is not 0 (0 is the most privileged level) and `cop_en_i` is 0, the request changes nothing, issues no memory write and sets `exc_unusable_o` with done. This takes priority over every other outcome.
- R4: A request accepted with `xlat_fault_i` high (and not unusable) changes nothing, issues no write and sets `exc_xlat_o` with done. It takes priority over `undef_o`.
- R5: Index operations (codes 0, 1, 2) select the line with `va[CACHE_BITS-1:LINE_BITS]` and ignore the stored tag.
- R6: Hit operations (codes 4, 5, 6) act only if the line at `pa[CACHE_BITS-1:LINE_BITS]` is valid and its tag equals `pa[ADDR_W-1:CACHE_BITS]`. Otherwise nothing changes and no write is issued.
- R7: A writeback issues 2^(LINE_BITS-3) beats in ascending order. Each beat has address {stored tag, line index, beat number, 3'b000} and carries that doubleword, and each beat is held stable until `mem_wready_i`.
- R8: Writeback-invalidate (code 0 index, code 5 hit) writes the line back only if it is valid and dirty. After the last beat is accepted it clears valid and dirty; a clean line is cleared at once. Hit invalidate (code 4) clears valid and dirty without writing.
- R9: Hit writeback (code 6) writes only a dirty hit line, then clears dirty and keeps valid.
- R10: Index store tag (code 2) writes tag, valid and dirty from `st_tag_i`, `st_valid_i` and `st_dirty_i`. Index load tag (code 1) returns them on `res_*`. With `ce_i` set, `va[LINE_BITS-1:3]` selects the doubleword that store tag writes from `st_data_i` and that load tag returns on `res_data_o`. With `ce_i` clear, no data is written and `res_data_o` is 0.
- R11: `req_ready_o` is high only when idle. `done_o` is a one-cycle pulse two cycles after acceptance when no write occurs, or one cycle after the last beat is accepted.
- R12: Operation codes 3 and 7 are no-ops that set `undef_o` with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| base_i | input | ADDR_W | Base register value |
| offset_i | input | 16 | Signed offset |
| cache_sel_i | input | 2 | Cache selector |
| op_i | input | 3 | Operation code |
| priv_i | input | 2 | Privilege level, 0 most privileged |
| cop_en_i | input | 1 | Coprocessor enable |
| ce_i | input | 1 | Cache-error control, doubleword select |
| st_tag_i | input | ADDR_W-CACHE_BITS | Tag for store tag |
| st_valid_i | input | 1 | Valid bit for store tag |
| st_dirty_i | input | 1 | Dirty bit for store tag |
| st_data_i | input | 64 | Doubleword for store tag with ce |
| va_o | output | ADDR_W | Effective virtual address to translation |
| pa_i | input | ADDR_W | Translated physical address |
| xlat_fault_i | input | 1 | Translation refill or invalid fault |
| mem_wvalid_o | output | 1 | Memory write beat valid |
| mem_wready_i | input | 1 | Memory write beat accepted |
| mem_waddr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | 64 | Memory write data |
| done_o | output | 1 | Request complete pulse |
| exc_unusable_o | output | 1 | Coprocessor-unusable, valid with done |
| exc_xlat_o | output | 1 | Translation fault, valid with done |
| undef_o | output | 1 | Undefined selector or code, valid with done |
| res_tag_o | output | ADDR_W-CACHE_BITS | Load-tag tag result |
| res_valid_o | output | 1 | Load-tag valid result |
| res_dirty_o | output | 1 | Load-tag dirty result |
| res_data_o | output | 64 | Load-tag doubleword result |

## Verification
The bench uses the default parameters: a 32-bit address, CACHE_BITS = 10 and LINE_BITS = 5. That gives 32 lines, 22-bit tags and four-beat writebacks, so the beat order and the address rebuilt from the tag can be checked beat by beat. Random requests are confined to eight line indices and three tags. This makes hits, tag mismatches, dirty hits and evictions of another tag frequent within a few hundred requests. Memory ready is stalled at random, so beats are held across waits.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  typedef enum logic [2:0] {
    OP_IDX_WBINV = 3'd0,
    OP_IDX_LDTAG = 3'd1,
    OP_IDX_STTAG = 3'd2,
    OP_HIT_INV   = 3'd4,
    OP_HIT_WBINV = 3'd5,
    OP_HIT_WB    = 3'd6
  } cmu_op_e;

  localparam logic [1:0] SEL_PDATA = 2'd1;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EXEC = 2'd1,
    S_WB   = 2'd2
  } cmu_state_e;
endpackage

// File: rtl/cmu_req_decode.sv
module cmu_req_decode
  import cmu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [15:0]       offset_i,
  input  logic [1:0]        cache_sel_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        priv_i,
  input  logic              cop_en_i,
  output logic [ADDR_W-1:0] va_o,
  output logic              unusable_o,
  output logic              defined_o,
  output logic              idx_op_o
);
  logic op_known;

  assign va_o       = base_i + {{(ADDR_W-16){offset_i[15]}}, offset_i};
  assign unusable_o = (priv_i != 2'd0) && !cop_en_i;

  always_comb begin
    unique case (op_i)
      OP_IDX_WBINV, OP_IDX_LDTAG, OP_IDX_STTAG,
      OP_HIT_INV, OP_HIT_WBINV, OP_HIT_WB: op_known = 1'b1;
      default:                             op_known = 1'b0;
    endcase
  end

  assign defined_o = op_known && (cache_sel_i == SEL_PDATA);
  assign idx_op_o  = !op_i[2];
endmodule

// File: rtl/cmu_line_store.sv
module cmu_line_store #(
  parameter int IDX_W  = 5,
  parameter int TAG_W  = 22,
  parameter int BEAT_W = 2,
  parameter int DW_W   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BEAT_W-1:0] dw_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [DW_W-1:0]   rd_data_o,
  input  logic              meta_we_i,
  input  logic              meta_valid_i,
  input  logic              meta_dirty_i,
  input  logic              tag_we_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              data_we_i,
  input  logic [DW_W-1:0]   data_i
);
  localparam int SETS  = 1 << IDX_W;
  localparam int BEATS = 1 << BEAT_W;

  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [DW_W-1:0]  data_q [SETS][BEATS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (meta_we_i) begin
      valid_q[idx_i] <= meta_valid_i;
      dirty_q[idx_i] <= meta_dirty_i;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[s] <= '0;
      end else if (tag_we_i && idx_i == IDX_W'(s)) begin
        tag_q[s] <= tag_i;
      end
    end
    for (genvar b = 0; b < BEATS; b++) begin : g_dw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          data_q[s][b] <= '0;
        end else if (data_we_i && idx_i == IDX_W'(s) && dw_i == BEAT_W'(b)) begin
          data_q[s][b] <= data_i;
        end
      end
    end
  end

  assign rd_tag_o   = tag_q[idx_i];
  assign rd_valid_o = valid_q[idx_i];
  assign rd_dirty_o = dirty_q[idx_i];
  assign rd_data_o  = data_q[idx_i][dw_i];
endmodule

// File: rtl/cache_maint_unit.sv
module cache_maint_unit
  import cmu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CACHE_BITS = 10,
  parameter int LINE_BITS  = 5,
  parameter int DW_W       = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic [ADDR_W-1:0]            base_i,
  input  logic [15:0]                  offset_i,
  input  logic [1:0]                   cache_sel_i,
  input  logic [2:0]                   op_i,
  input  logic [1:0]                   priv_i,
  input  logic                         cop_en_i,
  input  logic                         ce_i,
  input  logic [ADDR_W-CACHE_BITS-1:0] st_tag_i,
  input  logic                         st_valid_i,
  input  logic                         st_dirty_i,
  input  logic [DW_W-1:0]              st_data_i,
  output logic [ADDR_W-1:0]            va_o,
  input  logic [ADDR_W-1:0]            pa_i,
  input  logic                         xlat_fault_i,
  output logic                         mem_wvalid_o,
  input  logic                         mem_wready_i,
  output logic [ADDR_W-1:0]            mem_waddr_o,
  output logic [DW_W-1:0]              mem_wdata_o,
  output logic                         done_o,
  output logic                         exc_unusable_o,
  output logic                         exc_xlat_o,
  output logic                         undef_o,
  output logic [ADDR_W-CACHE_BITS-1:0] res_tag_o,
  output logic                         res_valid_o,
  output logic                         res_dirty_o,
  output logic [DW_W-1:0]              res_data_o
);
  localparam int TAG_W  = ADDR_W - CACHE_BITS;
  localparam int IDX_W  = CACHE_BITS - LINE_BITS;
  localparam int BEAT_W = LINE_BITS - 3;
  localparam int BEATS  = 1 << BEAT_W;

  cmu_state_e st_q, st_d;

  logic              dec_unusable, dec_defined, dec_idx_op;
  logic              unusable_q, fault_q, defined_q, idx_op_q, ce_q;
  logic [2:0]        op_q;
  logic [IDX_W-1:0]  va_idx_q, pa_idx_q, line_idx;
  logic [BEAT_W-1:0] va_dw_q, beat_q, dw_sel;
  logic [TAG_W-1:0]  pa_tag_q, st_tag_q;
  logic              st_valid_q, st_dirty_q;
  logic [DW_W-1:0]   st_data_q;
  logic              clr_valid_q, clr_valid_d, start_wb;
  logic              fin, ld_result;

  logic [TAG_W-1:0]  rd_tag;
  logic              rd_valid, rd_dirty, hit;
  logic [DW_W-1:0]   rd_data;
  logic              meta_we, meta_valid, meta_dirty, tag_we, data_we;

  logic              unused_pa;
  logic              accept;
  assign unused_pa = ^pa_i[LINE_BITS-1:0];

  cmu_req_decode #(.ADDR_W(ADDR_W)) u_dec (
    .base_i      (base_i),
    .offset_i    (offset_i),
    .cache_sel_i (cache_sel_i),
    .op_i        (op_i),
    .priv_i      (priv_i),
    .cop_en_i    (cop_en_i),
    .va_o        (va_o),
    .unusable_o  (dec_unusable),
    .defined_o   (dec_defined),
    .idx_op_o    (dec_idx_op)
  );

  assign req_ready_o = (st_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unusable_q <= 1'b0;
      fault_q    <= 1'b0;
      defined_q  <= 1'b0;
      idx_op_q   <= 1'b0;
      ce_q       <= 1'b0;
      op_q       <= '0;
      va_idx_q   <= '0;
      va_dw_q    <= '0;
      pa_idx_q   <= '0;
      pa_tag_q   <= '0;
      st_tag_q   <= '0;
      st_valid_q <= 1'b0;
      st_dirty_q <= 1'b0;
      st_data_q  <= '0;
    end else if (accept) begin
      unusable_q <= dec_unusable;
      fault_q    <= xlat_fault_i;
      defined_q  <= dec_defined;
      idx_op_q   <= dec_idx_op;
      ce_q       <= ce_i;
      op_q       <= op_i;
      va_idx_q   <= va_o[CACHE_BITS-1:LINE_BITS];
      va_dw_q    <= va_o[LINE_BITS-1:3];
      pa_idx_q   <= pa_i[CACHE_BITS-1:LINE_BITS];
      pa_tag_q   <= pa_i[ADDR_W-1:CACHE_BITS];
      st_tag_q   <= st_tag_i;
      st_valid_q <= st_valid_i;
      st_dirty_q <= st_dirty_i;
      st_data_q  <= st_data_i;
    end
  end

  // index ops address by virtual bits, hit ops by physical bits
  assign line_idx = idx_op_q ? va_idx_q : pa_idx_q;
  assign dw_sel   = (st_q == S_WB) ? beat_q : va_dw_q;

  cmu_line_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .BEAT_W(BEAT_W),
    .DW_W  (DW_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (line_idx),
    .dw_i        (dw_sel),
    .rd_tag_o    (rd_tag),
    .rd_valid_o  (rd_valid),
    .rd_dirty_o  (rd_dirty),
    .rd_data_o   (rd_data),
    .meta_we_i   (meta_we),
    .meta_valid_i(meta_valid),
    .meta_dirty_i(meta_dirty),
    .tag_we_i    (tag_we),
    .tag_i       (st_tag_q),
    .data_we_i   (data_we),
    .data_i      (st_data_q)
  );

  assign hit = rd_valid && (rd_tag == pa_tag_q);

  always_comb begin
    st_d        = st_q;
    meta_we     = 1'b0;
    meta_valid  = rd_valid;
    meta_dirty  = rd_dirty;
    tag_we      = 1'b0;
    data_we     = 1'b0;
    start_wb    = 1'b0;
    clr_valid_d = clr_valid_q;
    fin         = 1'b0;
    ld_result   = 1'b0;
    unique case (st_q)
      S_IDLE: if (req_valid_i) st_d = S_EXEC;
      S_EXEC: begin
        st_d = S_IDLE;
        fin  = 1'b1;
        if (!unusable_q && !fault_q && defined_q) begin
          unique case (op_q)
            OP_IDX_WBINV: begin
              if (rd_valid && rd_dirty) begin
                start_wb = 1'b1; clr_valid_d = 1'b1;
              end else begin
                meta_we = 1'b1; meta_valid = 1'b0; meta_dirty = 1'b0;
              end
            end
            OP_IDX_LDTAG: ld_result = 1'b1;
            OP_IDX_STTAG: begin
              meta_we    = 1'b1;
              tag_we     = 1'b1;
              meta_valid = st_valid_q;
              meta_dirty = st_dirty_q;
              data_we    = ce_q;
            end
            OP_HIT_INV: if (hit) begin
              meta_we = 1'b1; meta_valid = 1'b0; meta_dirty = 1'b0;
            end
            OP_HIT_WBINV: begin
              if (hit && rd_dirty) begin
                start_wb = 1'b1; clr_valid_d = 1'b1;
              end else if (hit) begin
                meta_we = 1'b1; meta_valid = 1'b0; meta_dirty = 1'b0;
              end
            end
            OP_HIT_WB: if (hit && rd_dirty) begin
              start_wb = 1'b1; clr_valid_d = 1'b0;
            end
            default: ;
          endcase
        end
        if (start_wb) begin
          st_d = S_WB;
          fin  = 1'b0;
        end
      end
      S_WB: begin
        if (mem_wready_i && beat_q == BEAT_W'(BEATS-1)) begin
          meta_we    = 1'b1;
          meta_valid = clr_valid_q ? 1'b0 : rd_valid;
          meta_dirty = 1'b0;
          st_d       = S_IDLE;
          fin        = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= S_IDLE;
      beat_q         <= '0;
      clr_valid_q    <= 1'b0;
      done_o         <= 1'b0;
      exc_unusable_o <= 1'b0;
      exc_xlat_o     <= 1'b0;
      undef_o        <= 1'b0;
      res_tag_o      <= '0;
      res_valid_o    <= 1'b0;
      res_dirty_o    <= 1'b0;
      res_data_o     <= '0;
    end else begin
      st_q        <= st_d;
      clr_valid_q <= clr_valid_d;
      if (start_wb) beat_q <= '0;
      else if (st_q == S_WB && mem_wready_i) beat_q <= beat_q + 1'b1;
      done_o         <= fin;
      exc_unusable_o <= fin && (st_q == S_EXEC) && unusable_q;
      exc_xlat_o     <= fin && (st_q == S_EXEC) && !unusable_q && fault_q;
      undef_o        <= fin && (st_q == S_EXEC) && !unusable_q && !fault_q && !defined_q;
      if (ld_result) begin
        res_tag_o   <= rd_tag;
        res_valid_o <= rd_valid;
        res_dirty_o <= rd_dirty;
        res_data_o  <= ce_q ? rd_data : '0;
      end
    end
  end

  assign mem_wvalid_o = (st_q == S_WB);
  assign mem_waddr_o  = {rd_tag, line_idx, beat_q, 3'b000};
  assign mem_wdata_o  = rd_data;

  // R7
  wb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wvalid_o && !mem_wready_i) |=>
      (mem_wvalid_o && $stable(mem_waddr_o) && $stable(mem_wdata_o)));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && !done_o));

  // R3
  unusable_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_EXEC && unusable_q) |=> (done_o && exc_unusable_o && !mem_wvalid_o));

  // R4
  status_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({exc_unusable_o, exc_xlat_o, undef_o}));

  // R9
  hit_wb_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wvalid_o && mem_wready_i && beat_q == BEAT_W'(BEATS-1) && !clr_valid_q)
      |=> (done_o && !mem_wvalid_o));
endmodule

// File: tb/tb_cache_maint_unit.sv
`timescale 1ns/1ps
module tb_cache_maint_unit;
  localparam int AW = 32;
  localparam int TW = 22;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [AW-1:0] base = '0;
  logic [15:0]   offset = '0;
  logic [1:0]    cache_sel = 2'd1, priv = '0;
  logic [2:0]    op = '0;
  logic          cop_en = 1'b0, ce = 1'b0;
  logic [TW-1:0] st_tag = '0;
  logic          st_valid = 1'b0, st_dirty = 1'b0;
  logic [63:0]   st_data = '0;
  logic [AW-1:0] va, pa;
  logic          xlat_fault = 1'b0;
  logic          mem_wvalid, mem_wready = 1'b0;
  logic [AW-1:0] mem_waddr;
  logic [63:0]   mem_wdata;
  logic          done, exc_unu, exc_xl, undef;
  logic [TW-1:0] res_tag;
  logic          res_valid, res_dirty;
  logic [63:0]   res_data;

  assign pa = va;  // identity translation stub

  cache_maint_unit dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .base_i(base), .offset_i(offset), .cache_sel_i(cache_sel), .op_i(op),
    .priv_i(priv), .cop_en_i(cop_en), .ce_i(ce),
    .st_tag_i(st_tag), .st_valid_i(st_valid), .st_dirty_i(st_dirty), .st_data_i(st_data),
    .va_o(va), .pa_i(pa), .xlat_fault_i(xlat_fault),
    .mem_wvalid_o(mem_wvalid), .mem_wready_i(mem_wready),
    .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .done_o(done), .exc_unusable_o(exc_unu), .exc_xlat_o(exc_xl), .undef_o(undef),
    .res_tag_o(res_tag), .res_valid_o(res_valid), .res_dirty_o(res_dirty), .res_data_o(res_data)
  );

  int checks = 0;
  int errors = 0;

  logic [TW-1:0] m_tag  [32];
  logic          m_v    [32];
  logic          m_d    [32];
  logic [63:0]   m_data [32][4];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] sel, input logic [2:0] opc, input logic [1:0] pv,
                        input logic cop, input logic cev, input logic flt,
                        input logic [TW-1:0] tg, input logic [4:0] ix, input logic [1:0] dw,
                        input logic [TW-1:0] stt, input logic sv, input logic sd,
                        input logic [63:0] sdat);
    logic [AW-1:0] eva;
    logic [15:0]   off;
    bit e_unu, e_xl, e_und, ok, e_hit, e_wb, e_clr;
    int beats, cyc;
    bit go;
    eva = {tg, ix, dw, 3'b000};
    off = 16'($urandom);
    e_unu = (pv != 2'd0) && !cop;
    e_xl  = !e_unu && flt;
    e_und = !e_unu && !e_xl &&
            ((sel != 2'd1) || opc == 3'd3 || opc == 3'd7);
    ok    = !e_unu && !e_xl && !e_und;
    e_hit = m_v[ix] && (m_tag[ix] == tg);
    e_wb  = ok && (((opc == 3'd0) && m_v[ix] && m_d[ix]) ||
                   ((opc == 3'd5 || opc == 3'd6) && e_hit && m_d[ix]));
    e_clr = (opc != 3'd6);

    @(negedge clk);
    req_valid = 1'b1; base = eva - {{16{off[15]}}, off}; offset = off;
    cache_sel = sel; op = opc; priv = pv; cop_en = cop; ce = cev; xlat_fault = flt;
    st_tag = stt; st_valid = sv; st_dirty = sd; st_data = sdat;
    #1;
    chk(va == eva, "R1", "effective address", 64'(va), 64'(eva));
    chk(req_ready == 1'b1, "R11", "ready when idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", "ready while busy", 64'(req_ready), 64'd0);
    cyc = 1; beats = 0;
    while (!done && cyc < 64) begin
      go = 1'b0;
      mem_wready = 1'b0;
      if (mem_wvalid) begin
        chk(beats < 4 && e_wb, "R7", "unexpected write beat", 64'(beats), 64'(e_wb));
        if (beats < 4) begin
          chk(mem_waddr == {m_tag[ix], ix, 2'(beats), 3'b000}, "R7", "beat address",
              64'(mem_waddr), 64'({m_tag[ix], ix, 2'(beats), 3'b000}));
          chk(mem_wdata == m_data[ix][beats], "R7", "beat data", mem_wdata, m_data[ix][beats]);
        end
        mem_wready = ($urandom % 3) != 0;
        go = mem_wready;
      end
      @(negedge clk);
      if (go) beats++;
      cyc++;
    end
    mem_wready = 1'b0;
    chk(done == 1'b1, "R11", "done seen", 64'(done), 64'd1);
    chk(beats == (e_wb ? 4 : 0), e_wb ? "R8" : "R6", "beat count", 64'(beats), 64'(e_wb ? 4 : 0));
    if (!e_wb) chk(cyc == 2, "R11", "done latency", 64'(cyc), 64'd2);
    chk(exc_unu == e_unu, "R3", "unusable flag", 64'(exc_unu), 64'(e_unu));
    chk(exc_xl == e_xl, "R4", "xlat flag", 64'(exc_xl), 64'(e_xl));
    chk(undef == e_und, (sel != 2'd1) ? "R2" : "R12", "undef flag", 64'(undef), 64'(e_und));
    if (ok && opc == 3'd1) begin
      chk(res_tag == m_tag[ix], "R10", "load tag", 64'(res_tag), 64'(m_tag[ix]));
      chk(res_valid == m_v[ix], "R10", "load valid", 64'(res_valid), 64'(m_v[ix]));
      chk(res_dirty == m_d[ix], "R10", "load dirty", 64'(res_dirty), 64'(m_d[ix]));
      chk(res_data == (cev ? m_data[ix][dw] : 64'd0), "R10", "load data",
          res_data, cev ? m_data[ix][dw] : 64'd0);
    end
    if (ok) begin
      unique case (opc)
        3'd0: begin m_v[ix] = 1'b0; m_d[ix] = 1'b0; end
        3'd2: begin
          m_tag[ix] = stt; m_v[ix] = sv; m_d[ix] = sd;
          if (cev) m_data[ix][dw] = sdat;
        end
        3'd4, 3'd5: if (e_hit) begin m_v[ix] = 1'b0; m_d[ix] = 1'b0; end
        3'd6: if (e_hit) m_d[ix] = 1'b0;
        default: ;
      endcase
    end
    if (e_wb && !e_clr) m_d[ix] = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", 64'(done), 64'd0);
  endtask

  localparam logic [TW-1:0] TB = 22'h2A000;

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) begin
      m_tag[i] = '0; m_v[i] = 1'b0; m_d[i] = 1'b0;
      for (int b = 0; b < 4; b++) m_data[i][b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk(req_ready == 1'b1 && done == 1'b0 && mem_wvalid == 1'b0, "R11", "reset state",
        64'({req_ready, done, mem_wvalid}), 64'b100);

    // R10 load tag after reset, then fill a dirty line word by word
    run_op(2'd1, 3'd1, 2'd0, 1'b0, 1'b1, 1'b0, TB, 5'd3, 2'd0, '0, 1'b0, 1'b0, '0);
    for (int b = 0; b < 4; b++)
      run_op(2'd1, 3'd2, 2'd1, 1'b1, 1'b1, 1'b0, TB, 5'd3, 2'(b), TB + 22'd1, 1'b1, 1'b1,
             {32'hC0DE0000, 32'(b)});
    run_op(2'd1, 3'd1, 2'd0, 1'b0, 1'b1, 1'b0, TB + 22'd9, 5'd3, 2'd2, '0, 1'b0, 1'b0, '0);
    // R6 hit writeback with wrong tag: no write
    run_op(2'd1, 3'd6, 2'd0, 1'b0, 1'b0, 1'b0, TB, 5'd3, 2'd0, '0, 1'b0, 1'b0, '0);
    // R9 dirty hit writeback: four beats, stays valid
    run_op(2'd1, 3'd6, 2'd0, 1'b0, 1'b0, 1'b0, TB + 22'd1, 5'd3, 2'd1, '0, 1'b0, 1'b0, '0);
    run_op(2'd1, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, TB, 5'd3, 2'd0, '0, 1'b0, 1'b0, '0);
    // R3 unusable beats translation fault; R4 fault alone
    run_op(2'd1, 3'd4, 2'd3, 1'b0, 1'b0, 1'b1, TB + 22'd1, 5'd3, 2'd0, '0, 1'b0, 1'b0, '0);
    run_op(2'd3, 3'd4, 2'd0, 1'b0, 1'b0, 1'b1, TB + 22'd1, 5'd3, 2'd0, '0, 1'b0, 1'b0, '0);
    // R2 other selector, R12 undefined code
    run_op(2'd0, 3'd4, 2'd0, 1'b0, 1'b0, 1'b0, TB + 22'd1, 5'd3, 2'd0, '0, 1'b0, 1'b0, '0);
    run_op(2'd1, 3'd7, 2'd0, 1'b0, 1'b0, 1'b0, TB + 22'd1, 5'd3, 2'd0, '0, 1'b0, 1'b0, '0);
    // R5 R8 index writeback-invalidate of a clean line with any tag: no write, cleared
    run_op(2'd1, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, TB + 22'd7, 5'd3, 2'd0, '0, 1'b0, 1'b0, '0);
    run_op(2'd1, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, TB, 5'd3, 2'd0, '0, 1'b0, 1'b0, '0);

    for (int n = 0; n < 400; n++) begin
      logic [1:0] sel, pv;
      sel = (($urandom % 10) == 0) ? 2'($urandom) : 2'd1;
      pv  = (($urandom % 6) == 0) ? 2'(1 + $urandom % 3) : 2'd0;
      run_op(sel, 3'($urandom), pv, 1'($urandom), 1'($urandom), ($urandom % 12) == 0,
             TB + 22'($urandom % 3), 5'($urandom % 8), 2'($urandom),
             TB + 22'($urandom % 3), 1'($urandom), 1'($urandom), {$urandom, $urandom});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule